// File: doc/BRIEF.md
# Read Latency Calibration Engine

At startup, a DDR read path has to be told how many controller clock cycles pass between a read command leaving the controller and its data reaching the capture registers. The rising-edge and falling-edge data paths can differ, so each needs its own answer. This engine finds both numbers. It writes a fixed four-word training sequence through the controller's command port and then runs one trial per candidate latency, from the smallest to the largest. Each trial reads the four words back. For every read issued, the engine samples each path's captured word that many cycles after the read. A candidate passes only if the four samples equal the four training words in order. The first passing candidate on each path becomes that path's latency.

Once calibration is done, the engine keeps a short shift line of read-issued pulses. Each path's FIFO write enable is the tap of that line selected by the path's latency, so every read produces its own capture strobe, even when reads come back to back. Either path's latency can be pinned to a fixed value through a force input. A forced value replaces the calibrated one. If a path is neither matched nor forced, the engine reports failure, uses latency 0 on that path, and still finishes.

Top module: `ltc_read_latency_cal`

## Requirements
- R1: After reset, the following outputs are 0: cal_done, cal_fail, both FIFO write enables and cmd_valid. With no force active, both latency outputs are also 0.
- R2: After a start pulse, the first four accepted commands are writes (cmd_write=1) with cmd_idx 0,1,2,3 and cmd_wdata 0xFFFF0000, 0xAAAA5555, 0x5555AAAA, 0x99996666 for those indices. A command held while cmd_ready is low keeps its index and kind.
- R3: Each trial issues exactly four reads (cmd_write=0) with cmd_idx 0..3 in order. Trials run for candidates 0,1,2,… and stop after the first candidate at which both paths are matched or forced, or after the last candidate. The total number of accepted reads is 4×(number of trials).
- R4: For a trial at candidate c, the rising-path sample of each read is rise_data exactly c cycles after the cycle in which rd_issued is high (c=0 means the same cycle). rise_lat becomes the smallest c whose four samples equal the training words in order. A candidate one cycle too short or too long is rejected.
- R5: The falling path is judged in the same way from fall_data and chooses fall_lat independently of the rising path.
- R6: If an unforced path matches no candidate, cal_fail=1 when cal_done rises, and that path's latency is 0.
- R7: While force_rise_en (force_fall_en) is 1, rise_lat (fall_lat) equals force_rise_lat (force_fall_lat). A forced path never causes cal_fail.
- R8: While cal_done=1, rise_fifo_we in a cycle equals rd_issued delayed by rise_lat cycles, and likewise for fall_fifo_we with fall_lat. Back-to-back reads give back-to-back strobes. Both enables are 0 while cal_done=0.
- R9: Calibrated latencies do not change between cal_done rising and the next start pulse. A new start pulse recalibrates.
- R10: In the cycle after an accepted start, cal_done=0 and cmd_valid=1. While cal_done=1, cmd_valid=0. A start pulse is accepted only when idle or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Start pulse for calibration |
| force_rise_en | input | 1 | Pin rising-path latency to force_rise_lat |
| force_rise_lat | input | LAT_W | Forced rising-path latency |
| force_fall_en | input | 1 | Pin falling-path latency to force_fall_lat |
| force_fall_lat | input | LAT_W | Forced falling-path latency |
| cmd_ready | input | 1 | Controller accepts the current command |
| cmd_valid | output | 1 | Command request valid |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_idx | output | 2 | Training word index / address |
| cmd_wdata | output | 32 | Write data for write commands |
| rd_issued | input | 1 | Pulse: a read command was issued this cycle |
| rise_data | input | 32 | Captured rising-edge word |
| fall_data | input | 32 | Captured falling-edge word |
| cal_done | output | 1 | Calibration finished |
| cal_fail | output | 1 | An unforced path found no matching candidate |
| rise_lat | output | LAT_W | Effective rising-path latency |
| fall_lat | output | LAT_W | Effective falling-path latency |
| rise_fifo_we | output | 1 | Rising-path FIFO write strobe |
| fall_fifo_we | output | 1 | Falling-path FIFO write strobe |

## Verification
The hardest case to reach is a path whose data never lines up with any candidate while the other path does. The trial loop then has to run through every candidate, report failure, and still leave the matched path's value in place. The bench reaches this by giving its memory model a latency beyond the candidate range on one path. Off-by-one rejection is exercised by randomly stalling cmd_ready. With stalls, neighbouring reads sit at varied distances, so a wrong candidate samples either a neighbour's word or idle junk.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
    localparam int WORD_W  = 32;
    localparam int PAT_LEN = 4;
    localparam int IDX_W   = $clog2(PAT_LEN);
    localparam int CNT_W   = $clog2(PAT_LEN + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_DRAIN,
        ST_DONE
    } cal_state_e;

    typedef struct packed {
        logic              write;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] wdata;
    } cal_cmd_t;

    // Training sequence; order matters for the in-order comparison.
    function automatic logic [WORD_W-1:0] train_word(input logic [IDX_W-1:0] i);
        case (i)
            2'd0:    train_word = 32'hFFFF_0000;
            2'd1:    train_word = 32'hAAAA_5555;
            2'd2:    train_word = 32'h5555_AAAA;
            default: train_word = 32'h9999_6666;
        endcase
    endfunction
endpackage

// File: rtl/ltc_tap_line.sv
module ltc_tap_line #(
    parameter int NUM_LAT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pulse,
    output logic [NUM_LAT-1:0] taps
);
    logic [NUM_LAT-2:0] hist;

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[NUM_LAT-3:0], pulse};
    end

    assign taps[0] = pulse;
    for (genvar k = 1; k < NUM_LAT; k++) begin : g_tap
        assign taps[k] = hist[k-1];
    end
endmodule

// File: rtl/ltc_path_judge.sv
module ltc_path_judge
    import ltc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              strobe,
    input  logic [WORD_W-1:0] data,
    output logic              pass
);
    logic [CNT_W-1:0] seen;
    logic             good;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            seen <= '0;
            good <= 1'b1;
        end else if (strobe) begin
            if (seen < CNT_W'(PAT_LEN)) begin
                good <= good && (data == train_word(seen[IDX_W-1:0]));
                seen <= seen + 1'b1;
            end else begin
                good <= 1'b0;   // surplus strobe: sequence misaligned
            end
        end
    end

    assign pass = good && (seen == CNT_W'(PAT_LEN));
endmodule

// File: rtl/ltc_seq.sv
module ltc_seq
    import ltc_pkg::*;
#(
    parameter int NUM_LAT = 8,
    parameter int LAT_W   = $clog2(NUM_LAT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmd_ready,
    input  logic             rd_issued,
    input  logic             pass_rise,
    input  logic             pass_fall,
    input  logic             force_rise_en,
    input  logic             force_fall_en,
    output logic             cmd_valid,
    output cal_cmd_t         cmd,
    output logic [LAT_W-1:0] cand,
    output logic             trial_clr,
    output logic             cal_done,
    output logic             cal_fail,
    output logic [LAT_W-1:0] lat_rise,
    output logic [LAT_W-1:0] lat_fall
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAT_LEN - 1);
    localparam logic [LAT_W-1:0] LAST_LAT = LAT_W'(NUM_LAT - 1);

    cal_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] issued, returned;
    logic [LAT_W-1:0] drain;
    logic             found_r, found_f;
    logic             accept, decide, finish, rise_ok, fall_ok;

    assign cmd_valid = (state == ST_WRITE) ||
                       (state == ST_READ && issued < CNT_W'(PAT_LEN));
    assign cmd.write = (state == ST_WRITE);
    assign cmd.idx   = idx;
    assign cmd.wdata = (state == ST_WRITE) ? train_word(idx) : '0;
    assign accept    = cmd_valid && cmd_ready;

    assign decide  = (state == ST_DRAIN) && (drain == LAST_LAT);
    assign rise_ok = found_r || pass_rise || force_rise_en;
    assign fall_ok = found_f || pass_fall || force_fall_en;
    assign finish  = decide && ((rise_ok && fall_ok) || cand == LAST_LAT);
    assign trial_clr = (state == ST_WRITE && accept && idx == LAST_IDX) ||
                       (decide && !finish);
    assign cal_done  = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            issued   <= '0;
            returned <= '0;
            drain    <= '0;
            cand     <= '0;
            found_r  <= 1'b0;
            found_f  <= 1'b0;
            lat_rise <= '0;
            lat_fall <= '0;
            cal_fail <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state    <= ST_WRITE;
                        idx      <= '0;
                        cand     <= '0;
                        found_r  <= 1'b0;
                        found_f  <= 1'b0;
                        lat_rise <= '0;
                        lat_fall <= '0;
                        cal_fail <= 1'b0;
                    end
                end
                ST_WRITE: begin
                    if (accept) begin
                        idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
                        if (idx == LAST_IDX) begin
                            state    <= ST_READ;
                            issued   <= '0;
                            returned <= '0;
                        end
                    end
                end
                ST_READ: begin
                    if (accept) begin
                        issued <= issued + 1'b1;
                        idx    <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
                    end
                    if (rd_issued) begin
                        if (returned == CNT_W'(PAT_LEN - 1)) begin
                            state <= ST_DRAIN;
                            drain <= '0;
                        end else begin
                            returned <= returned + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    drain <= drain + 1'b1;
                    if (decide) begin
                        if (pass_rise && !found_r) begin
                            found_r  <= 1'b1;
                            lat_rise <= cand;
                        end
                        if (pass_fall && !found_f) begin
                            found_f  <= 1'b1;
                            lat_fall <= cand;
                        end
                        if (finish) begin
                            state    <= ST_DONE;
                            cal_fail <= !(rise_ok && fall_ok);
                        end else begin
                            cand     <= cand + 1'b1;
                            state    <= ST_READ;
                            issued   <= '0;
                            returned <= '0;
                            idx      <= '0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ltc_read_latency_cal.sv
module ltc_read_latency_cal
    import ltc_pkg::*;
#(
    parameter int NUM_LAT = 8,
    parameter int LAT_W   = $clog2(NUM_LAT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_start,
    input  logic              force_rise_en,
    input  logic [LAT_W-1:0]  force_rise_lat,
    input  logic              force_fall_en,
    input  logic [LAT_W-1:0]  force_fall_lat,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [WORD_W-1:0] cmd_wdata,
    input  logic              rd_issued,
    input  logic [WORD_W-1:0] rise_data,
    input  logic [WORD_W-1:0] fall_data,
    output logic              cal_done,
    output logic              cal_fail,
    output logic [LAT_W-1:0]  rise_lat,
    output logic [LAT_W-1:0]  fall_lat,
    output logic              rise_fifo_we,
    output logic              fall_fifo_we
);
    logic [NUM_LAT-1:0] taps;
    logic [LAT_W-1:0]   cand, cal_rise, cal_fall;
    logic               trial_clr, pass_rise, pass_fall, cand_strobe;
    cal_cmd_t           cmd;

    ltc_tap_line #(.NUM_LAT(NUM_LAT)) u_taps (
        .clk(clk), .rst(rst), .pulse(rd_issued), .taps(taps)
    );

    assign cand_strobe = taps[cand] && !cal_done;

    ltc_path_judge u_judge_rise (
        .clk(clk), .rst(rst), .clear(trial_clr),
        .strobe(cand_strobe), .data(rise_data), .pass(pass_rise)
    );

    ltc_path_judge u_judge_fall (
        .clk(clk), .rst(rst), .clear(trial_clr),
        .strobe(cand_strobe), .data(fall_data), .pass(pass_fall)
    );

    ltc_seq #(.NUM_LAT(NUM_LAT), .LAT_W(LAT_W)) u_seq (
        .clk(clk), .rst(rst), .start(cal_start), .cmd_ready(cmd_ready),
        .rd_issued(rd_issued), .pass_rise(pass_rise), .pass_fall(pass_fall),
        .force_rise_en(force_rise_en), .force_fall_en(force_fall_en),
        .cmd_valid(cmd_valid), .cmd(cmd), .cand(cand), .trial_clr(trial_clr),
        .cal_done(cal_done), .cal_fail(cal_fail),
        .lat_rise(cal_rise), .lat_fall(cal_fall)
    );

    assign cmd_write = cmd.write;
    assign cmd_idx   = cmd.idx;
    assign cmd_wdata = cmd.wdata;

    assign rise_lat     = force_rise_en ? force_rise_lat : cal_rise;
    assign fall_lat     = force_fall_en ? force_fall_lat : cal_fall;
    assign rise_fifo_we = cal_done && taps[rise_lat];
    assign fall_fifo_we = cal_done && taps[fall_lat];
endmodule

// File: rtl/ltc_cal_checker.sv
module ltc_cal_checker #(
    parameter int LAT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cal_done,
    input logic             cal_fail,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_write,
    input logic [1:0]       cmd_idx,
    input logic             rd_issued,
    input logic [LAT_W-1:0] rise_lat,
    input logic             rise_fifo_we,
    input logic             fall_fifo_we,
    input logic             force_rise_en
);
    p_we_gated_r8: assert property (@(posedge clk) disable iff (rst)
        !cal_done |-> !(rise_fifo_we || fall_fifo_we));

    p_we_zero_lat_r8: assert property (@(posedge clk) disable iff (rst)
        (cal_done && rise_lat == '0 && rd_issued) |-> rise_fifo_we);

    p_cmd_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> !cmd_valid);

    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_idx) && $stable(cmd_write)));

    p_fail_done_r6: assert property (@(posedge clk) disable iff (rst)
        cal_fail |-> cal_done);

    p_lat_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (cal_done && $past(cal_done) && !force_rise_en && !$past(force_rise_en))
        |-> $stable(rise_lat));
endmodule

bind ltc_read_latency_cal ltc_cal_checker #(.LAT_W(LAT_W)) u_ltc_chk (
    .clk(clk), .rst(rst), .cal_done(cal_done), .cal_fail(cal_fail),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_idx(cmd_idx), .rd_issued(rd_issued), .rise_lat(rise_lat),
    .rise_fifo_we(rise_fifo_we), .fall_fifo_we(fall_fifo_we),
    .force_rise_en(force_rise_en)
);

// File: tb/test_ltc_read_latency_cal.sv
module test_ltc_read_latency_cal;
    localparam int NL = 8;
    localparam logic [31:0] JUNK_R = 32'h0000_0000;
    localparam logic [31:0] JUNK_F = 32'h1234_5678;

    logic        clk = 1'b0, rst = 1'b1, cal_start = 1'b0;
    logic        force_rise_en = 1'b0, force_fall_en = 1'b0;
    logic [2:0]  force_rise_lat = '0, force_fall_lat = '0;
    logic        cmd_ready = 1'b0, cmd_valid, cmd_write;
    logic [1:0]  cmd_idx;
    logic [31:0] cmd_wdata, rise_data, fall_data;
    logic        rd_issued, cal_done, cal_fail, rise_fifo_we, fall_fifo_we;
    logic [2:0]  rise_lat, fall_lat;

    int n_chk = 0, n_bad = 0, cycles = 0;
    int true_r = 0, true_f = 0;
    bit rdy_mode = 1'b1;
    logic       rd_q = 1'b0, inj = 1'b0;
    logic [1:0] ridx_q = '0, inj_idx = '0, cur_idx;
    logic [7:0] hv = '0;
    logic [1:0] hi [0:7];
    int wr_n = 0, wr_bad = 0, rd_n = 0, rd_bad = 0;

    always #2 clk = ~clk;

    ltc_read_latency_cal i_ltc_read_latency_cal (
        .clk(clk), .rst(rst), .cal_start(cal_start),
        .force_rise_en(force_rise_en), .force_rise_lat(force_rise_lat),
        .force_fall_en(force_fall_en), .force_fall_lat(force_fall_lat),
        .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .rd_issued(rd_issued),
        .rise_data(rise_data), .fall_data(fall_data), .cal_done(cal_done),
        .cal_fail(cal_fail), .rise_lat(rise_lat), .fall_lat(fall_lat),
        .rise_fifo_we(rise_fifo_we), .fall_fifo_we(fall_fifo_we)
    );

    function automatic logic [31:0] pat(input logic [1:0] i);
        case (i)
            2'd0: return 32'hFFFF_0000;
            2'd1: return 32'hAAAA_5555;
            2'd2: return 32'h5555_AAAA;
            default: return 32'h9999_6666;
        endcase
    endfunction

    // Memory model: word for read k shows up exactly lat cycles after its pulse.
    function automatic logic [31:0] model_word(input int lat, input logic [31:0] junk);
        if (lat >= NL) return junk;
        if (lat == 0) return rd_issued ? pat(cur_idx) : junk;
        return hv[lat-1] ? pat(hi[lat-1]) : junk;
    endfunction

    assign rd_issued = rd_q | inj;
    assign cur_idx   = rd_q ? ridx_q : inj_idx;
    always_comb begin
        rise_data = model_word(true_r, JUNK_R);
        fall_data = model_word(true_f, JUNK_F);
    end

    always @(posedge clk) begin
        rd_q   <= cmd_valid && cmd_ready && !cmd_write;
        ridx_q <= cmd_idx;
        hv     <= {hv[6:0], rd_issued};
        hi[0]  <= cur_idx;
        for (int k = 1; k < 8; k++) hi[k] <= hi[k-1];
        if (cal_start) begin
            wr_n <= 0; wr_bad <= 0; rd_n <= 0; rd_bad <= 0;
        end else if (cmd_valid && cmd_ready) begin
            if (cmd_write) begin
                if (wr_n >= 4 || cmd_idx != wr_n[1:0] || cmd_wdata != pat(wr_n[1:0]))
                    wr_bad <= wr_bad + 1;
                wr_n <= wr_n + 1;
            end else begin
                if (wr_n < 4 || cmd_idx != rd_n[1:0]) rd_bad <= rd_bad + 1;
                rd_n <= rd_n + 1;
            end
        end
    end

    always @(negedge clk) cmd_ready <= rdy_mode ? 1'b1 : (($urandom % 3) != 0);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_cal(input int r, input int f, input bit fre, input int frl,
                           input bit ffe, input int ffl, input bit rdy);
        int cyc = 0;
        int rs, fs, trials, er, ef;
        bit efail;
        @(negedge clk);
        true_r = r; true_f = f; rdy_mode = rdy;
        force_rise_en = fre; force_rise_lat = frl[2:0];
        force_fall_en = ffe; force_fall_lat = ffl[2:0];
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        chk(!cal_done && cmd_valid, "R10", "busy after start", {cal_done, cmd_valid}, 1);
        while (!cal_done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cal_done, "R10", "done reached", cal_done, 1);
        rs = fre ? 0 : (r < NL ? r : NL - 1);
        fs = ffe ? 0 : (f < NL ? f : NL - 1);
        trials = (rs > fs ? rs : fs) + 1;
        er = fre ? frl : (r < NL ? r : 0);
        ef = ffe ? ffl : (f < NL ? f : 0);
        efail = (!fre && r >= NL) || (!ffe && f >= NL);
        chk(rise_lat == er[2:0], efail ? "R6" : (fre ? "R7" : "R4"), "rise_lat", rise_lat, er);
        chk(fall_lat == ef[2:0], efail ? "R6" : (ffe ? "R7" : "R5"), "fall_lat", fall_lat, ef);
        chk(cal_fail == efail, "R6", "cal_fail", cal_fail, efail);
        chk(wr_n == 4 && wr_bad == 0, "R2", "training writes", wr_n * 100 + wr_bad, 400);
        chk(rd_n == 4 * trials && rd_bad == 0, "R3", "trial reads", rd_n * 100 + rd_bad, 400 * trials);
    endtask

    task automatic check_we(input int n);
        logic [2:0] lr = rise_lat, lf = fall_lat;
        logic er, ef;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            er = (lr == 0) ? rd_issued : hv[lr-1];
            ef = (lf == 0) ? rd_issued : hv[lf-1];
            chk(rise_fifo_we == er, "R8", "rise_fifo_we", rise_fifo_we, er);
            chk(fall_fifo_we == ef, "R8", "fall_fifo_we", fall_fifo_we, ef);
            inj     = ($urandom % 2) == 1;
            inj_idx = 2'($urandom % 4);
        end
        @(negedge clk);
        inj = 1'b0;
        chk(rise_lat == lr && fall_lat == lf, "R9", "latency frozen",
            {rise_lat, fall_lat}, {lr, lf});
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cal_done && !cal_fail && !cmd_valid && !rise_fifo_we && !fall_fifo_we
            && rise_lat == 0 && fall_lat == 0, "R1", "reset state",
            {cal_done, cal_fail, cmd_valid, rise_fifo_we, fall_fifo_we}, 0);

        run_cal(3, 5, 0, 0, 0, 0, 1);          // R4 R5 distinct latencies
        check_we(40);
        run_cal(0, 7, 0, 0, 0, 0, 0);          // R4 extremes, stalled ready
        check_we(40);
        run_cal(99, 2, 0, 0, 0, 0, 0);         // R6 rising path never matches
        run_cal(2, 4, 1, 6, 0, 0, 1);          // R7 rising forced
        check_we(30);
        run_cal(99, 99, 1, 1, 1, 3, 0);        // R7 both forced, one trial
        check_we(30);
        for (int t = 0; t < 8; t++) begin      // R9 recalibration, random mix
            int r = $urandom % 10, f = $urandom % 10;
            if (r >= NL) r = 99;
            if (f >= NL) f = 99;
            run_cal(r, f, 0, 0, 0, 0, ($urandom % 2) == 1);
            check_we(20);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule